// File: doc/BRIEF.md
# Multi-mode 24-bit counter/timer channel

This block is one counter/timer channel inside a larger data-acquisition device. A host drives it through four 16-bit registers: a data port split into a low word and a high word, a mode word, and a command word. The 24-bit counter has two event sources. It can count the edges of a two-phase quadrature encoder at one, two or four counts per encoder cycle. It can also count a synchronous internal clock-enable input, with the direction set by software. A gating input can enable or block counting. The gate can come from software, from the level of the index input, or from a capture/output flag (the "capture flag").

The two 24-bit preload values serve two purposes. They seed the counter through commands, and they reload the counter on a rising index edge. Two generator modes also use both preloads. The single-pulse mode runs one low/high sequence and then parks with the capture flag set. The pulse-train mode repeats the sequence with no end. The output pin shows either the capture flag or the generator phase, with a selectable inversion. Reads of the counter are coherent: reading the low word freezes the upper byte, so a following high-word read matches it.

Top module: `ctr_timer_chan`

## Requirements
- R1: After reset the counter reads 0, the capture flag is 0, the mode word is 0 (counting disabled) and the output pin is 0.
- R2: Register address 0 reads counter bits 15:0. Address 1 reads the upper counter byte in bits 7:0, with bits 15:8 as zero. Address 2 reads back the mode word. When mode bit 13 is 0, a read of address 0 freezes the upper byte, and address 1 returns that frozen byte. When bit 13 is 1, address 1 returns the live upper byte.
- R3: A write to address 1 only stages the upper preload byte (wdata[7:0]). A write to address 0 commits {staged byte, wdata} to preload 0 when mode bit 14 is 0, and to preload 1 when bit 14 is 1. A staged byte alone never changes a preload.
- R4: Writing address 3 with bit 15 set clears the counter. Writing it with bit 14 set loads preload 0 into the counter. When both bits are set, the load wins. Both take effect on the next clock edge.
- R5: Writing address 3 with bit 3 set clears the capture flag. In the generator modes (mode bits 4:2 = 1 or 2) the same write also loads preload 0 and sets the generator phase to 0.
- R6: With mode bit 12 = 1, each clock cycle with the tick input high and counting enabled moves the counter by one. Mode bit 11 = 0 counts up and 1 counts down. The counter wraps modulo 2^24, and each wrap sets the capture flag.
- R7: With mode bit 12 = 0, the counter follows the synchronised encoder inputs. The encoder resolution is set by mode bits 10:9:
  - 0 counts each rising edge of A, up when B is low and down when B is high.
  - 1 counts every A edge.
  - 2 or 3 counts every A and B edge.
  - The direction follows the A-leads-B order, where A leading means up.
- R8: A change of both encoder inputs in the same synchronised sample is ignored and leaves the counter unchanged.
- R9: Mode bits 8:7 select the enable:
  - 0 disables counting.
  - 1 enables counting always.
  - 2 or 3 gate counting by the source in bits 6:5: 0 is index high, 1 is index low, 2 is the capture flag set, and 3 is the capture flag clear.
- R10: With mode bits 4:2 = 4, a rising edge on the index input loads preload 0 into the counter. In other auto modes the index edge has no effect on the count.
- R11: Single-pulse (bits 4:2 = 1) counts down from preload 0 while the phase is 0, then counts preload 1 while the phase is 1. It then reloads preload 0, sets the capture flag and stops when gated by the clear capture flag. A segment loaded with N lasts N events.
- R12: Pulse-train (bits 4:2 = 2) alternates the phase between 0 for preload 0 events and 1 for preload 1 events, and repeats this with no end.
- R13: The output pin equals (mode bit 0 ? generator phase : capture flag) XOR mode bit 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (drives read-side capture) |
| bus_addr | input | 2 | Register select: 0 low data, 1 high data, 2 mode, 3 command |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational from the address |
| enc_a | input | 1 | Encoder phase A (asynchronous) |
| enc_b | input | 1 | Encoder phase B (asynchronous) |
| enc_idx | input | 1 | Index input (asynchronous) |
| tick | input | 1 | Internal count enable, synchronous |
| cnt_out | output | 1 | Output pin |
| rcap_flag | output | 1 | Capture flag |

## Verification
Each stimulus has a fixed latency to its result, and every check is sampled at or after that point:
- Register writes and commands reach the counter, the preloads and the mode word at the clock edge that samples the strobe. The bench reads them back one falling edge later.
- A tick counts at the edge on which it is high.
- Encoder and index pins pass through two synchroniser flops and one edge-detect flop. A pin change therefore reaches the count at the third rising edge. The bench waits four cycles after each pin change before reading.
- For the pulse train, the bench samples the output pin at each falling edge while tick is held high. It compares each sample with a segment model built only from the two preload values.

// File: rtl/ctr_timer_pkg.sv
package ctr_timer_pkg;

    localparam int BUS_W = 16;

    // mode word, field order fixed by software-visible bit positions
    typedef struct packed {
        logic       rsvd;        // 15
        logic       pr_sel;      // 14 : preload target of data writes
        logic       latch_live;  // 13 : 0 = freeze upper byte on low read
        logic       dir_sw;      // 12 : 1 = tick input with software direction
        logic       dir_down;    // 11
        logic [1:0] clk_src;     // 10:9 quadrature resolution
        logic [1:0] en_ctl;      // 8:7
        logic [1:0] hw_src;      // 6:5
        logic [2:0] auto_mode;   // 4:2
        logic       out_pol;     // 1
        logic       out_src;     // 0
    } mode_t;

    localparam logic [2:0] AUTO_SW      = 3'd0;
    localparam logic [2:0] AUTO_ONESHOT = 3'd1;
    localparam logic [2:0] AUTO_TRAIN   = 3'd2;
    localparam logic [2:0] AUTO_INDEX   = 3'd4;

    localparam logic [1:0] ADDR_LO   = 2'd0;
    localparam logic [1:0] ADDR_HI   = 2'd1;
    localparam logic [1:0] ADDR_MODE = 2'd2;
    localparam logic [1:0] ADDR_CTRL = 2'd3;

    localparam int CTL_CLR  = 15;
    localparam int CTL_LOAD = 14;
    localparam int CTL_ARM  = 3;

    typedef struct packed {
        logic clr;
        logic load;
        logic arm;
    } ctl_cmd_t;

endpackage

// File: rtl/ctr_sync.sv
module ctr_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] stage_d [STAGES];
    logic [W-1:0] stage_q [STAGES];

    always_comb begin
        stage_d[0] = din;
        for (int i = 1; i < STAGES; i++) begin
            stage_d[i] = stage_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) begin
                stage_q[i] <= '0;
            end
        end else begin
            for (int i = 0; i < STAGES; i++) begin
                stage_q[i] <= stage_d[i];
            end
        end
    end

    assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/ctr_quad_dec.sv
module ctr_quad_dec (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       a,
    input  logic       b,
    input  logic       idx,
    input  logic [1:0] res,
    output logic       step,
    output logic       up,
    output logic       idx_rise
);
    typedef struct packed {
        logic a;
        logic b;
        logic idx;
    } prev_t;

    prev_t prev_d, prev_q;
    logic  a_chg, b_chg;

    assign a_chg = a ^ prev_q.a;
    assign b_chg = b ^ prev_q.b;

    always_comb begin
        prev_d   = {a, b, idx};
        step     = 1'b0;
        up       = 1'b0;
        idx_rise = idx & ~prev_q.idx;
        // a simultaneous change of both phases carries no direction
        if (!(a_chg && b_chg)) begin
            case (res)
                2'd0: begin
                    step = a_chg & a;
                    up   = ~b;
                end
                2'd1: begin
                    step = a_chg;
                    up   = a ^ b;
                end
                default: begin
                    step = a_chg | b_chg;
                    up   = a_chg ? (a ^ b) : ~(a ^ b);
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= prev_d;
    end
endmodule

// File: rtl/ctr_core.sv
module ctr_core
    import ctr_timer_pkg::*;
#(
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  mode_t            mode,
    input  logic             cmd_vld,
    input  ctl_cmd_t         cmd,
    input  logic [CNT_W-1:0] pr0,
    input  logic [CNT_W-1:0] pr1,
    input  logic             tick,
    input  logic             step,
    input  logic             step_up,
    input  logic             idx_rise,
    input  logic             idx_lvl,
    output logic [CNT_W-1:0] count,
    output logic             rcap,
    output logic             phase
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    typedef struct packed {
        logic [CNT_W-1:0] count;
        logic             rcap;
        logic             phase;
    } core_t;

    core_t core_d, core_q;
    logic  en, evt, go_up, gen;
    logic  unused_mode_bits;

    assign unused_mode_bits = ^{mode.rsvd, mode.pr_sel, mode.latch_live,
                                mode.clk_src, mode.out_pol, mode.out_src};

    always_comb begin
        case (mode.en_ctl)
            2'd0:    en = 1'b0;
            2'd1:    en = 1'b1;
            default: begin
                case (mode.hw_src)
                    2'd0:    en = idx_lvl;
                    2'd1:    en = ~idx_lvl;
                    2'd2:    en = core_q.rcap;
                    default: en = ~core_q.rcap;
                endcase
            end
        endcase
        evt   = mode.dir_sw ? tick : step;
        go_up = mode.dir_sw ? ~mode.dir_down : step_up;
        gen   = (mode.auto_mode == AUTO_ONESHOT) || (mode.auto_mode == AUTO_TRAIN);

        core_d = core_q;

        if (en && evt) begin
            if (gen) begin
                if (core_q.count <= CNT_ONE) begin
                    if (!core_q.phase) begin
                        core_d.count = pr1;
                        core_d.phase = 1'b1;
                    end else begin
                        core_d.count = pr0;
                        core_d.phase = 1'b0;
                        if (mode.auto_mode == AUTO_ONESHOT) core_d.rcap = 1'b1;
                    end
                end else begin
                    core_d.count = core_q.count - CNT_ONE;
                end
            end else if (go_up) begin
                core_d.count = core_q.count + CNT_ONE;
                if (core_q.count == CNT_MAX) core_d.rcap = 1'b1;
            end else begin
                core_d.count = core_q.count - CNT_ONE;
                if (core_q.count == '0) core_d.rcap = 1'b1;
            end
        end

        if ((mode.auto_mode == AUTO_INDEX) && idx_rise) begin
            core_d.count = pr0;
        end

        // commands override counting; load is applied after clear
        if (cmd_vld) begin
            if (cmd.clr) begin
                core_d.count = '0;
                core_d.phase = 1'b0;
            end
            if (cmd.load) begin
                core_d.count = pr0;
                core_d.phase = 1'b0;
            end
            if (cmd.arm) begin
                core_d.rcap = 1'b0;
                if (gen) begin
                    core_d.count = pr0;
                    core_d.phase = 1'b0;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) core_q <= '0;
        else        core_q <= core_d;
    end

    assign count = core_q.count;
    assign rcap  = core_q.rcap;
    assign phase = core_q.phase;
endmodule

// File: rtl/ctr_timer_chan.sv
module ctr_timer_chan
    import ctr_timer_pkg::*;
#(
    parameter int CNT_W       = 24,
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_wr,
    input  logic        bus_rd,
    input  logic [1:0]  bus_addr,
    input  logic [15:0] bus_wdata,
    output logic [15:0] bus_rdata,
    input  logic        enc_a,
    input  logic        enc_b,
    input  logic        enc_idx,
    input  logic        tick,
    output logic        cnt_out,
    output logic        rcap_flag
);
    localparam int HI_W  = CNT_W - BUS_W;
    localparam int PAD_W = BUS_W - HI_W;

    typedef struct packed {
        mode_t            mode;
        logic [CNT_W-1:0] pr0;
        logic [CNT_W-1:0] pr1;
        logic [HI_W-1:0]  hold;
        logic [HI_W-1:0]  hi_snap;
    } regs_t;

    regs_t            regs_d, regs_q;
    logic [2:0]       pins_s;
    logic             a_s, b_s, idx_s;
    logic             step, step_up, idx_rise;
    logic             cmd_vld;
    ctl_cmd_t         cmd;
    logic [CNT_W-1:0] count;
    logic             rcap, phase;
    mode_t            mode_cur;
    logic [CNT_W-1:0] pr0_cur;

    ctr_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({enc_a, enc_b, enc_idx}),
        .dout (pins_s)
    );
    assign a_s   = pins_s[2];
    assign b_s   = pins_s[1];
    assign idx_s = pins_s[0];

    ctr_quad_dec u_dec (
        .clk     (clk),
        .rst_n   (rst_n),
        .a       (a_s),
        .b       (b_s),
        .idx     (idx_s),
        .res     (regs_q.mode.clk_src),
        .step    (step),
        .up      (step_up),
        .idx_rise(idx_rise)
    );

    assign cmd_vld = bus_wr && (bus_addr == ADDR_CTRL);
    assign cmd     = {bus_wdata[CTL_CLR], bus_wdata[CTL_LOAD], bus_wdata[CTL_ARM]};

    ctr_core #(.CNT_W(CNT_W)) u_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .mode    (regs_q.mode),
        .cmd_vld (cmd_vld),
        .cmd     (cmd),
        .pr0     (regs_q.pr0),
        .pr1     (regs_q.pr1),
        .tick    (tick),
        .step    (step),
        .step_up (step_up),
        .idx_rise(idx_rise),
        .idx_lvl (idx_s),
        .count   (count),
        .rcap    (rcap),
        .phase   (phase)
    );

    always_comb begin
        regs_d = regs_q;
        if (bus_wr) begin
            case (bus_addr)
                ADDR_LO: begin
                    if (regs_q.mode.pr_sel) regs_d.pr1 = {regs_q.hold, bus_wdata};
                    else                    regs_d.pr0 = {regs_q.hold, bus_wdata};
                end
                ADDR_HI:   regs_d.hold = bus_wdata[HI_W-1:0];
                ADDR_MODE: regs_d.mode = mode_t'(bus_wdata);
                default:   ;
            endcase
        end
        if (bus_rd && (bus_addr == ADDR_LO)) begin
            regs_d.hi_snap = count[CNT_W-1:BUS_W];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    always_comb begin
        case (bus_addr)
            ADDR_LO:   bus_rdata = count[BUS_W-1:0];
            ADDR_HI:   bus_rdata = {{PAD_W{1'b0}},
                                    regs_q.mode.latch_live ? count[CNT_W-1:BUS_W]
                                                           : regs_q.hi_snap};
            ADDR_MODE: bus_rdata = regs_q.mode;
            default:   bus_rdata = '0;
        endcase
    end

    assign cnt_out   = (regs_q.mode.out_src ? phase : rcap) ^ regs_q.mode.out_pol;
    assign rcap_flag = rcap;
    assign mode_cur  = regs_q.mode;
    assign pr0_cur   = regs_q.pr0;
endmodule

// File: rtl/ctr_timer_chan_chk.sv
module ctr_timer_chan_chk
    import ctr_timer_pkg::*;
#(
    parameter int CNT_W = 24
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_wr,
    input logic [1:0]       bus_addr,
    input logic [15:0]      bus_wdata,
    input mode_t            mode,
    input logic [CNT_W-1:0] pr0,
    input logic [CNT_W-1:0] count,
    input logic             rcap,
    input logic             a_s,
    input logic             b_s
);
    logic ctl_wr, gen;
    assign ctl_wr = bus_wr && (bus_addr == ADDR_CTRL);
    assign gen    = (mode.auto_mode == AUTO_ONESHOT) || (mode.auto_mode == AUTO_TRAIN);

    // R4: clear without load leaves zero
    assert_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && bus_wdata[15] && !bus_wdata[14] && !(bus_wdata[3] && gen))
        |=> (count == '0))
        else $error("clear command did not zero the counter");

    // R4: load command copies preload 0
    assert_load_pr0_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && bus_wdata[14]) |=> (count == $past(pr0)))
        else $error("load command did not copy preload 0");

    // R5: arm clears capture flag
    assert_arm_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && bus_wdata[3]) |=> !rcap)
        else $error("arm command left capture flag set");

    // R8: double transition leaves the count alone
    assert_illegal_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode.dir_sw && (mode.auto_mode != AUTO_INDEX) && !ctl_wr &&
         (a_s != $past(a_s)) && (b_s != $past(b_s)))
        |=> $stable(count))
        else $error("double encoder transition changed the count");

    // R9: disabled counter holds
    assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode.en_ctl == 2'd0) && !ctl_wr && (mode.auto_mode != AUTO_INDEX))
        |=> $stable(count))
        else $error("disabled counter moved");
endmodule

bind ctr_timer_chan ctr_timer_chan_chk #(.CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .mode     (mode_cur),
    .pr0      (pr0_cur),
    .count    (count),
    .rcap     (rcap),
    .a_s      (a_s),
    .b_s      (b_s)
);

// File: tb/ctr_timer_chan_tb.sv
module ctr_timer_chan_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [1:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        enc_a = 1'b0, enc_b = 1'b0, enc_idx = 1'b0, tick = 1'b0;
    logic        cnt_out, rcap_flag;

    int n_tests = 0;
    int n_fail  = 0;

    always #2 clk = ~clk;   // 250 MHz

    ctr_timer_chan u_dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .enc_a(enc_a), .enc_b(enc_b), .enc_idx(enc_idx), .tick(tick),
        .cnt_out(cnt_out), .rcap_flag(rcap_flag)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [15:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic read_cnt(output logic [23:0] v);
        logic [15:0] lo, hi;
        rd(2'd0, lo);
        rd(2'd1, hi);
        v = {hi[7:0], lo};
    endtask

    task automatic load_cnt(input logic [23:0] v);
        wr(2'd1, {8'h00, v[23:16]});
        wr(2'd0, v[15:0]);
        wr(2'd3, 16'h4000);
    endtask

    task automatic tick_n(input int n);
        @(negedge clk);
        tick = 1'b1;
        repeat (n) @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic quad_to(input logic a, input logic b);
        @(negedge clk);
        enc_a = a; enc_b = b;
        repeat (4) @(negedge clk);
    endtask

    task automatic fwd_cycle();
        quad_to(1, 0); quad_to(1, 1); quad_to(0, 1); quad_to(0, 0);
    endtask

    task automatic rev_cycle();
        quad_to(0, 1); quad_to(1, 1); quad_to(1, 0); quad_to(0, 0);
    endtask

    task automatic t_reset();
        logic [23:0] v;
        logic [15:0] m;
        read_cnt(v);
        check("R1 count", v, 0);
        rd(2'd2, m);
        check("R1 mode", m, 0);
        check("R1 rcap", rcap_flag, 0);
        check("R1 out", cnt_out, 0);
    endtask

    task automatic t_preload();
        logic [23:0] v;
        wr(2'd2, 16'h0000);
        wr(2'd1, 16'h0012);
        wr(2'd0, 16'h3456);
        wr(2'd3, 16'h4000);
        read_cnt(v);
        check("R3 preload commit", v, 24'h123456);
        wr(2'd1, 16'h0077);
        wr(2'd3, 16'h4000);
        read_cnt(v);
        check("R3 staged byte only", v, 24'h123456);
        wr(2'd3, 16'h8000);
        read_cnt(v);
        check("R4 clear", v, 0);
        wr(2'd1, 16'h0012);
        wr(2'd0, 16'h3456);
        wr(2'd3, 16'hC000);
        read_cnt(v);
        check("R4 clear+load", v, 24'h123456);
    endtask

    task automatic t_latch();
        logic [15:0] d;
        wr(2'd2, 16'h1080);
        load_cnt(24'h00FFFF);
        rd(2'd0, d);
        check("R2 low word", d, 16'hFFFF);
        tick_n(1);
        rd(2'd1, d);
        check("R2 frozen upper byte", d, 16'h0000);
        wr(2'd2, 16'h3080);
        rd(2'd1, d);
        check("R2 live upper byte", d, 16'h0001);
        load_cnt(24'hAB0000);
        rd(2'd1, d);
        check("R2 high word pad", d, 16'h00AB);
        rd(2'd2, d);
        check("R2 mode readback", d, 16'h3080);
    endtask

    task automatic t_sw_count();
        logic [23:0] v;
        wr(2'd2, 16'h1880);
        load_cnt(24'h000002);
        wr(2'd3, 16'h0008);
        tick_n(3);
        read_cnt(v);
        check("R6 down wrap", v, 24'hFFFFFF);
        check("R6 wrap sets flag", rcap_flag, 1);
        check("R13 out follows flag", cnt_out, 1);
        wr(2'd2, 16'h1080);
        load_cnt(24'hFFFFFE);
        wr(2'd3, 16'h0008);
        check("R5 arm clears flag", rcap_flag, 0);
        tick_n(2);
        read_cnt(v);
        check("R6 up wrap", v, 24'h000000);
        check("R6 up wrap flag", rcap_flag, 1);
    endtask

    task automatic t_quad();
        logic [23:0] v;
        wr(2'd2, 16'h0680);
        wr(2'd3, 16'h8000);
        fwd_cycle(); fwd_cycle();
        read_cnt(v);
        check("R7 x4 forward", v, 8);
        rev_cycle();
        read_cnt(v);
        check("R7 x4 reverse", v, 4);
        wr(2'd2, 16'h0280);
        wr(2'd3, 16'h8000);
        fwd_cycle();
        read_cnt(v);
        check("R7 x2 forward", v, 2);
        wr(2'd2, 16'h0080);
        wr(2'd3, 16'h8000);
        fwd_cycle();
        read_cnt(v);
        check("R7 x1 forward", v, 1);
        rev_cycle();
        read_cnt(v);
        check("R7 x1 reverse", v, 0);
    endtask

    task automatic t_illegal();
        logic [23:0] v;
        wr(2'd2, 16'h0680);
        wr(2'd3, 16'h8000);
        quad_to(1, 1);
        quad_to(0, 0);
        read_cnt(v);
        check("R8 double transition", v, 0);
    endtask

    task automatic t_enable();
        logic [23:0] v;
        wr(2'd2, 16'h1000);
        load_cnt(24'h000010);
        tick_n(5);
        read_cnt(v);
        check("R9 disabled", v, 24'h10);
        wr(2'd2, 16'h1100);
        tick_n(3);
        read_cnt(v);
        check("R9 gated by index low", v, 24'h10);
        @(negedge clk); enc_idx = 1'b1;
        repeat (4) @(negedge clk);
        read_cnt(v);
        check("R10 no reload outside index mode", v, 24'h10);
        tick_n(3);
        read_cnt(v);
        check("R9 index high enables", v, 24'h13);
        @(negedge clk); enc_idx = 1'b0;
        repeat (4) @(negedge clk);
        wr(2'd2, 16'h1160);
        wr(2'd3, 16'h0008);
        tick_n(2);
        read_cnt(v);
        check("R9 gated by clear flag", v, 24'h15);
    endtask

    task automatic t_index();
        logic [23:0] v;
        wr(2'd2, 16'h0690);
        wr(2'd1, 16'h0000);
        wr(2'd0, 16'h0100);
        wr(2'd3, 16'h8000);
        @(negedge clk); enc_idx = 1'b1;
        repeat (4) @(negedge clk);
        read_cnt(v);
        check("R10 index reload", v, 24'h100);
        quad_to(1, 0);
        read_cnt(v);
        check("R10 counts after reload", v, 24'h101);
        @(negedge clk); enc_idx = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic t_oneshot();
        logic [23:0] v;
        wr(2'd2, 16'h1166);
        wr(2'd1, 16'h0000); wr(2'd0, 16'h0003);
        wr(2'd2, 16'h5166);
        wr(2'd1, 16'h0000); wr(2'd0, 16'h0002);
        wr(2'd2, 16'h1166);
        wr(2'd3, 16'h0008);
        check("R5 arm clears flag", rcap_flag, 0);
        check("R13 inverted flag out", cnt_out, 1);
        tick_n(2);
        read_cnt(v);
        check("R11 first segment", v, 1);
        tick_n(8);
        read_cnt(v);
        check("R11 parked count", v, 3);
        check("R11 flag set at end", rcap_flag, 1);
        check("R13 out after pulse", cnt_out, 0);
    endtask

    task automatic t_train();
        int rem = 3;
        logic ph = 1'b0;
        wr(2'd2, 16'h1089);
        wr(2'd1, 16'h0000); wr(2'd0, 16'h0003);
        wr(2'd2, 16'h5089);
        wr(2'd1, 16'h0000); wr(2'd0, 16'h0002);
        wr(2'd2, 16'h1089);
        wr(2'd3, 16'h0008);
        check("R13 phase out idle", cnt_out, 0);
        @(negedge clk);
        tick = 1'b1;
        for (int k = 0; k < 10; k++) begin
            @(negedge clk);
            if (rem <= 1) begin
                ph  = ~ph;
                rem = ph ? 2 : 3;
            end else begin
                rem--;
            end
            check("R12 train phase", cnt_out, ph);
        end
        tick = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_preload();
        t_latch();
        t_sw_count();
        t_quad();
        t_illegal();
        t_enable();
        t_index();
        t_oneshot();
        t_train();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule